// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a 32-bit in-order integer core. Every instruction passes through five single-cycle stages: fetch, decode, execute, memory and write-back. Registers between the stages hold each instruction's operands and its control bits. The control bits travel with the instruction, and each stage drops the group it has used. The core fetches through an instruction port that returns the word at the current fetch address in the same cycle. It reads and writes whole words through a data port. It holds 32 general registers.

The core decodes a small integer subset: register add, subtract, and, or and signed set-less-than, add-immediate, word load, word store, and branch-if-equal. It has no hazard interlock and no operand forwarding. The program must space a consumer at least three instructions after the instruction that produces its value. A branch is resolved when it reaches the memory stage. When it is taken, the core discards the three instructions fetched after it.

A user connects the two memory ports to instruction and data storage, asserts `rst` for at least one clock, and releases it. Fetch then starts at address zero.

Top module: `rv5_core`

## Requirements
- R1: While `rst` is high at a clock edge, the fetch address returns to 0 and the data port makes no read and no write on the next cycle. The pipeline then holds only no-ops.
- R2: Without a taken branch, the fetch address advances by 4 on every clock edge. One instruction is fetched per cycle.
- R3: Register instructions (opcode 0110011) compute rd = rs1 op rs2. The operation is chosen by funct3 and funct7: add (000/0000000), sub (000/0100000), and (111/0000000), or (110/0000000), and signed set-less-than (010/0000000), which writes 1 or 0.
- R4: Add-immediate (opcode 0010011, funct3 000) adds the sign-extended 12-bit field in bits 31:20 to rs1.
- R5: Word load (opcode 0000011, funct3 010) puts the read data at address rs1 + sign-extended bits 31:20 into rd. Word store (opcode 0100011, funct3 010) writes rs2 at address rs1 + the sign-extended field {bits 31:25, bits 11:7}. A cycle never has both a read and a write strobe.
- R6: An instruction latched at fetch edge t shows its data access on the port between edges t+2 and t+3. Its register result is written at edge t+4. Straight-line code retires one instruction per cycle.
- R7: Branch-if-equal (opcode 1100011, funct3 000) with equal operands loads the fetch address with its own address plus the B-format offset. This happens at edge t+3. The three instructions that follow it perform no access and no write. With unequal operands, fetch continues in sequence.
- R8: Register x0 reads as zero. Writes aimed at it have no effect.
- R9: A value written back in a cycle is seen by a decode read of the same register in that cycle. A consumer placed three instructions after its producer therefore gets the new value.
- R10: Any encoding outside the listed subset, including other funct3 or funct7 values of the same opcodes, behaves as a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Fetch byte address |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Data byte address of the memory-stage access |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe; memory writes at the next edge |
| dmem_re | output | 1 | Load strobe |
| dmem_rdata | input | 32 | Load data for `dmem_addr`, same cycle |

## Verification
The checks assume a legal program. No instruction reads a register written by either of the two instructions just before it. Branches jump forward inside the program. Data accesses are word aligned, and the instruction port answers every fetch. The random generator records the destinations of the last two instructions and draws source registers outside that set. It pads with no-ops after the register set-up and before the final register dump. It bases every load and store on x0 or a fixed base register, with aligned offsets. Branch offsets are positive multiples of four within the program image.

// File: rtl/rv5_pkg.sv
package rv5_pkg;

    localparam int ILEN   = 32;
    localparam int REG_AW = 5;
    localparam int NREG   = 1 << REG_AW;

    localparam logic [6:0] OPC_REG   = 7'b0110011;
    localparam logic [6:0] OPC_IMM   = 7'b0010011;
    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;
    localparam logic [6:0] OPC_BEQ   = 7'b1100011;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_op_e;

    // consumed in execute
    typedef struct packed {
        alu_op_e op;
        logic    use_imm;
    } ex_ctl_t;

    // consumed in the memory stage
    typedef struct packed {
        logic is_beq;
        logic rd_mem;
        logic wr_mem;
    } mem_ctl_t;

    // consumed in write-back
    typedef struct packed {
        logic wr_reg;
        logic from_mem;
    } wb_ctl_t;

endpackage

// File: rtl/rv5_alu.sv
module rv5_alu
    import rv5_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = ($signed(a) < $signed(b)) ? XLEN'(1) : '0;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/rv5_decode.sv
module rv5_decode
    import rv5_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [ILEN-1:0]   instr,
    output ex_ctl_t           ex_o,
    output mem_ctl_t          mem_o,
    output wb_ctl_t           wb_o,
    output logic [XLEN-1:0]   imm_o,
    output logic [REG_AW-1:0] rs1_o,
    output logic [REG_AW-1:0] rs2_o,
    output logic [REG_AW-1:0] rd_o
);

    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;
    logic [XLEN-1:0] imm_i, imm_s, imm_b;

    assign opc   = instr[6:0];
    assign f3    = instr[14:12];
    assign f7    = instr[31:25];
    assign rd_o  = instr[11:7];
    assign rs1_o = instr[19:15];
    assign rs2_o = instr[24:20];

    assign imm_i = {{(XLEN-12){instr[31]}}, instr[31:20]};
    assign imm_s = {{(XLEN-12){instr[31]}}, instr[31:25], instr[11:7]};
    assign imm_b = {{(XLEN-13){instr[31]}}, instr[31], instr[7],
                    instr[30:25], instr[11:8], 1'b0};

    always_comb begin
        ex_o.op      = ALU_ADD;
        ex_o.use_imm = 1'b0;
        mem_o        = '0;
        wb_o         = '0;
        imm_o        = '0;
        unique case (opc)
            OPC_REG: begin
                if (f7 == 7'h00) begin
                    wb_o.wr_reg = 1'b1;
                    unique case (f3)
                        3'b000:  ex_o.op = ALU_ADD;
                        3'b111:  ex_o.op = ALU_AND;
                        3'b110:  ex_o.op = ALU_OR;
                        3'b010:  ex_o.op = ALU_SLT;
                        default: wb_o.wr_reg = 1'b0;
                    endcase
                end else if (f7 == 7'h20 && f3 == 3'b000) begin
                    wb_o.wr_reg = 1'b1;
                    ex_o.op     = ALU_SUB;
                end
            end
            OPC_IMM: begin
                if (f3 == 3'b000) begin
                    wb_o.wr_reg  = 1'b1;
                    ex_o.use_imm = 1'b1;
                    imm_o        = imm_i;
                end
            end
            OPC_LOAD: begin
                if (f3 == 3'b010) begin
                    wb_o.wr_reg   = 1'b1;
                    wb_o.from_mem = 1'b1;
                    mem_o.rd_mem  = 1'b1;
                    ex_o.use_imm  = 1'b1;
                    imm_o         = imm_i;
                end
            end
            OPC_STORE: begin
                if (f3 == 3'b010) begin
                    mem_o.wr_mem = 1'b1;
                    ex_o.use_imm = 1'b1;
                    imm_o        = imm_s;
                end
            end
            OPC_BEQ: begin
                if (f3 == 3'b000) begin
                    mem_o.is_beq = 1'b1;
                    ex_o.op      = ALU_SUB;
                    imm_o        = imm_b;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rv5_regfile.sv
module rv5_regfile #(
    parameter int XLEN = 32,
    parameter int NR   = 32,
    parameter int NRD  = 2
) (
    input  logic                             clk,
    input  logic [NRD-1:0][$clog2(NR)-1:0]   ra,
    output logic [NRD-1:0][XLEN-1:0]         rdata,
    input  logic                             we,
    input  logic [$clog2(NR)-1:0]            wa,
    input  logic [XLEN-1:0]                  wd
);

    logic [XLEN-1:0] regs [NR];

    always_ff @(posedge clk) begin
        if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    // read ports: x0 is zero, a same-cycle write is passed straight through
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = (ra[p] == '0)             ? '0 :
                          (we && wa == ra[p])       ? wd :
                                                      regs[ra[p]];
    end

endmodule

// File: rtl/rv5_core.sv
module rv5_core
    import rv5_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [ILEN-1:0] imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    output logic            dmem_re,
    input  logic [XLEN-1:0] dmem_rdata
);

    localparam logic [XLEN-1:0] STEP = XLEN'(ILEN / 8);

    // ---------------- fetch ----------------
    logic [XLEN-1:0] pc_q, pc_step;
    logic            br_taken;
    logic [XLEN-1:0] exmem_tgt;

    assign pc_step   = pc_q + STEP;
    assign imem_addr = pc_q;

    always_ff @(posedge clk) begin
        if (rst)           pc_q <= '0;
        else if (br_taken) pc_q <= exmem_tgt;
        else               pc_q <= pc_step;
    end

    logic [ILEN-1:0] ifid_instr;
    logic [XLEN-1:0] ifid_pc4;

    always_ff @(posedge clk) begin
        if (rst || br_taken) ifid_instr <= '0;
        else                 ifid_instr <= imem_rdata;
    end

    always_ff @(posedge clk) begin
        ifid_pc4 <= pc_step;
    end

    // ---------------- decode ----------------
    ex_ctl_t           id_ex;
    mem_ctl_t          id_mem;
    wb_ctl_t           id_wb;
    logic [XLEN-1:0]   id_imm;
    logic [REG_AW-1:0] id_rs1, id_rs2, id_rd;
    logic [1:0][REG_AW-1:0] rf_ra;
    logic [1:0][XLEN-1:0]   rf_rd;
    logic              wb_we;
    logic [REG_AW-1:0] memwb_rd;
    logic [XLEN-1:0]   wb_data;

    rv5_decode #(.XLEN(XLEN)) u_dec (
        .instr (ifid_instr),
        .ex_o  (id_ex),
        .mem_o (id_mem),
        .wb_o  (id_wb),
        .imm_o (id_imm),
        .rs1_o (id_rs1),
        .rs2_o (id_rs2),
        .rd_o  (id_rd)
    );

    assign rf_ra[0] = id_rs1;
    assign rf_ra[1] = id_rs2;

    rv5_regfile #(.XLEN(XLEN), .NR(NREG), .NRD(2)) u_rf (
        .clk   (clk),
        .ra    (rf_ra),
        .rdata (rf_rd),
        .we    (wb_we),
        .wa    (memwb_rd),
        .wd    (wb_data)
    );

    ex_ctl_t           idex_ex;
    mem_ctl_t          idex_mem;
    wb_ctl_t           idex_wb;
    logic [XLEN-1:0]   idex_rd1, idex_rd2, idex_imm, idex_pc4;
    logic [REG_AW-1:0] idex_rs1, idex_rs2, idex_rd;

    always_ff @(posedge clk) begin
        if (rst || br_taken) begin
            idex_ex  <= '0;
            idex_mem <= '0;
            idex_wb  <= '0;
        end else begin
            idex_ex  <= id_ex;
            idex_mem <= id_mem;
            idex_wb  <= id_wb;
        end
    end

    always_ff @(posedge clk) begin
        idex_rd1 <= rf_rd[0];
        idex_rd2 <= rf_rd[1];
        idex_imm <= id_imm;
        idex_pc4 <= ifid_pc4;
        idex_rs1 <= id_rs1;
        idex_rs2 <= id_rs2;
        idex_rd  <= id_rd;
    end

    // ---------------- execute ----------------
    logic [XLEN-1:0] ex_b, ex_y, ex_tgt;

    assign ex_b   = idex_ex.use_imm ? idex_imm : idex_rd2;
    assign ex_tgt = idex_pc4 - STEP + idex_imm;

    rv5_alu #(.XLEN(XLEN)) u_alu (
        .a  (idex_rd1),
        .b  (ex_b),
        .op (idex_ex.op),
        .y  (ex_y)
    );

    mem_ctl_t          exmem_mem;
    wb_ctl_t           exmem_wb;
    logic [XLEN-1:0]   exmem_alu, exmem_rd2;
    logic              exmem_zero;
    logic [REG_AW-1:0] exmem_rd;

    always_ff @(posedge clk) begin
        if (rst || br_taken) begin
            exmem_mem <= '0;
            exmem_wb  <= '0;
        end else begin
            exmem_mem <= idex_mem;
            exmem_wb  <= idex_wb;
        end
    end

    always_ff @(posedge clk) begin
        exmem_alu  <= ex_y;
        exmem_zero <= (ex_y == '0);
        exmem_tgt  <= ex_tgt;
        exmem_rd2  <= idex_rd2;
        exmem_rd   <= idex_rd;
    end

    // ---------------- memory ----------------
    assign br_taken   = exmem_mem.is_beq & exmem_zero;
    assign dmem_addr  = exmem_alu;
    assign dmem_wdata = exmem_rd2;
    assign dmem_we    = exmem_mem.wr_mem;
    assign dmem_re    = exmem_mem.rd_mem;

    wb_ctl_t         memwb_wb;
    logic [XLEN-1:0] memwb_alu, memwb_ld;

    always_ff @(posedge clk) begin
        if (rst) memwb_wb <= '0;
        else     memwb_wb <= exmem_wb;
    end

    always_ff @(posedge clk) begin
        memwb_alu <= exmem_alu;
        memwb_ld  <= dmem_rdata;
        memwb_rd  <= exmem_rd;
    end

    // ---------------- write-back ----------------
    assign wb_we   = memwb_wb.wr_reg;
    assign wb_data = memwb_wb.from_mem ? memwb_ld : memwb_alu;

endmodule

// File: rtl/rv5_core_chk.sv
module rv5_core_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] imem_addr,
    input logic            dmem_we,
    input logic            dmem_re,
    input logic            br_taken,
    input logic [XLEN-1:0] br_target,
    input logic [4:0]      idex_rs1,
    input logic [4:0]      idex_rs2,
    input logic [XLEN-1:0] idex_rd1,
    input logic [XLEN-1:0] idex_rd2
);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (imem_addr == '0 && !dmem_we && !dmem_re));

    p_seq_fetch_r2: assert property (@(posedge clk) disable iff (rst)
        !br_taken |=> imem_addr == $past(imem_addr) + XLEN'(4));

    p_one_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        !(dmem_we && dmem_re));

    p_redirect_r7: assert property (@(posedge clk) disable iff (rst)
        br_taken |=> imem_addr == $past(br_target));

    p_squash_mem_r7: assert property (@(posedge clk) disable iff (rst)
        br_taken |=> (!dmem_we && !dmem_re && !br_taken));

    p_zero_src1_r8: assert property (@(posedge clk) disable iff (rst)
        (idex_rs1 == 5'd0) |-> idex_rd1 == '0);

    p_zero_src2_r8: assert property (@(posedge clk) disable iff (rst)
        (idex_rs2 == 5'd0) |-> idex_rd2 == '0);

endmodule

bind rv5_core rv5_core_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .dmem_we   (dmem_we),
    .dmem_re   (dmem_re),
    .br_taken  (br_taken),
    .br_target (exmem_tgt),
    .idex_rs1  (idex_rs1),
    .idex_rs2  (idex_rs2),
    .idex_rd1  (idex_rd1),
    .idex_rd2  (idex_rd2)
);

// File: tb/sim_rv5_core.sv
module sim_rv5_core;

    localparam int CLK_NS = 10;
    localparam int IMW    = 128;
    localparam int DMW    = 64;
    localparam int RUN    = 400;
    localparam int MAXEXP = 256;
    localparam logic [31:0] NOP = 32'h0000_0013;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata;
    logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we, dmem_re;

    always #(CLK_NS/2) clk = ~clk;

    rv5_core #(.XLEN(32)) u0 (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_re    (dmem_re),
        .dmem_rdata (dmem_rdata)
    );

    logic [31:0] prog [IMW];
    logic [31:0] dmem [DMW];

    assign imem_rdata = (imem_addr < 32'(IMW * 4)) ? prog[imem_addr[8:2]] : NOP;
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
    end

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // expected store trace from the instruction-level model
    int          n_exp;
    int          k_seen;
    int          exp_cyc  [MAXEXP];
    logic [31:0] exp_addr [MAXEXP];
    logic [31:0] exp_data [MAXEXP];
    string       cur_tag;

    function automatic logic [31:0] init_word(int i);
        return 32'hA500_0000 ^ (32'(i) * 32'h0101_0101);
    endfunction

    function automatic logic [31:0] enc_r(logic [6:0] f7, int rs2, int rs1, logic [2:0] f3, int rd);
        return {f7, 5'(rs2), 5'(rs1), f3, 5'(rd), 7'h33};
    endfunction
    function automatic logic [31:0] enc_i(int imm, int rs1, int rd);
        return {12'(imm), 5'(rs1), 3'b000, 5'(rd), 7'h13};
    endfunction
    function automatic logic [31:0] enc_lw(int imm, int rs1, int rd);
        return {12'(imm), 5'(rs1), 3'b010, 5'(rd), 7'h03};
    endfunction
    function automatic logic [31:0] enc_sw(int imm, int rs2, int rs1);
        logic [11:0] v;
        v = 12'(imm);
        return {v[11:5], 5'(rs2), 5'(rs1), 3'b010, v[4:0], 7'h23};
    endfunction
    function automatic logic [31:0] enc_beq(int off, int rs1, int rs2);
        logic [12:0] v;
        v = 13'(off);
        return {v[12], v[10:5], 5'(rs2), 5'(rs1), 3'b000, v[4:1], v[11], 7'h63};
    endfunction

    task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    // instruction-level model: order of execution, store trace and its cycles
    task automatic ref_run();
        logic [31:0] r [32];
        logic [31:0] m [DMW];
        logic [31:0] w, a, b, ii, is, ib, val, ad;
        logic [6:0]  op, f7;
        logic [2:0]  f3;
        int pc, t, guard, nxt, dt, rd;
        bit wr;
        pc = 0; t = 1; guard = 0; n_exp = 0;
        for (int i = 0; i < 32; i++) r[i] = '0;
        for (int i = 0; i < DMW; i++) m[i] = init_word(i);
        while (pc < IMW && guard < 4096) begin
            w  = prog[pc];
            op = w[6:0]; f3 = w[14:12]; f7 = w[31:25]; rd = int'(w[11:7]);
            a  = r[w[19:15]]; b = r[w[24:20]];
            ii = {{20{w[31]}}, w[31:20]};
            is = {{20{w[31]}}, w[31:25], w[11:7]};
            ib = {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
            nxt = pc + 1; dt = 1; wr = 0; val = '0;
            if (op == 7'h33 && (f7 == 7'h00 || (f7 == 7'h20 && f3 == 3'b000))) begin
                wr = 1;
                case (f3)
                    3'b000:  val = f7[5] ? a - b : a + b;
                    3'b111:  val = a & b;
                    3'b110:  val = a | b;
                    3'b010:  val = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default: wr = 0;
                endcase
            end else if (op == 7'h13 && f3 == 3'b000) begin
                wr = 1; val = a + ii;
            end else if (op == 7'h03 && f3 == 3'b010) begin
                ad = a + ii; wr = 1; val = m[ad[7:2]];
            end else if (op == 7'h23 && f3 == 3'b010) begin
                ad = a + is;
                m[ad[7:2]] = b;
                if (n_exp < MAXEXP) begin
                    exp_cyc[n_exp]  = t + 2;
                    exp_addr[n_exp] = ad;
                    exp_data[n_exp] = b;
                    n_exp++;
                end
            end else if (op == 7'h63 && f3 == 3'b000 && a == b) begin
                nxt = pc + int'($signed(ib)) / 4;
                dt  = 4;
            end
            if (wr && rd != 0) r[rd] = val;
            pc = nxt; t += dt; guard++;
        end
    endtask

    // store monitor: every strobe must match the next expected store (R5, R6, R7)
    always @(negedge clk) begin
        if (!rst && dmem_we) begin
            n_chk++;
            if (k_seen >= n_exp) begin
                n_bad++;
                $display("FAIL %s unexpected store: actual addr=%h data=%h cyc=%0d expected none",
                         cur_tag, dmem_addr, dmem_wdata, cyc);
            end else if (cyc != exp_cyc[k_seen] || dmem_addr != exp_addr[k_seen] ||
                         dmem_wdata != exp_data[k_seen]) begin
                n_bad++;
                $display("FAIL %s store #%0d: actual cyc=%0d addr=%h data=%h expected cyc=%0d addr=%h data=%h",
                         cur_tag, k_seen, cyc, dmem_addr, dmem_wdata,
                         exp_cyc[k_seen], exp_addr[k_seen], exp_data[k_seen]);
            end
            k_seen++;
        end
    end

    task automatic run_prog(string tag, bit pc_chk);
        ref_run();
        cur_tag = tag;
        k_seen  = 0;
        rst     = 1'b1;
        for (int i = 0; i < DMW; i++) dmem[i] = init_word(i);
        repeat (3) @(negedge clk);
        check(imem_addr == 32'd0 && !dmem_we && !dmem_re,
              "R1 reset state (fetch addr, strobes)", {imem_addr[29:0], dmem_we, dmem_re}, 32'd0);
        rst = 1'b0;
        for (int c = 0; c < RUN; c++) begin
            @(negedge clk);
            if (pc_chk && cyc >= 1 && cyc <= 6)
                check(imem_addr == 32'(4 * cyc), "R2 sequential fetch address",
                      imem_addr, 32'(4 * cyc));
        end
        check(k_seen == n_exp, {tag, " store count"}, 32'(k_seen), 32'(n_exp));
    endtask

    task automatic clear_prog();
        for (int i = 0; i < IMW; i++) prog[i] = NOP;
    endtask

    task automatic gen_random();
        int p, l1, l2, rs1, rs2, rd, kind, sel;
        p = 0; l1 = 0; l2 = 0;
        clear_prog();
        for (int i = 1; i < 30; i++) prog[p++] = enc_i(int'($urandom_range(0, 4095)), 0, i);
        prog[p++] = enc_i(64, 0, 30);
        prog[p++] = NOP;
        prog[p++] = NOP;
        for (int s = 0; s < 56; s++) begin
            do rs1 = int'($urandom_range(0, 29)); while (rs1 != 0 && (rs1 == l1 || rs1 == l2));
            do rs2 = int'($urandom_range(0, 29)); while (rs2 != 0 && (rs2 == l1 || rs2 == l2));
            rd   = int'($urandom_range(0, 29));
            kind = int'($urandom_range(0, 9));
            if (kind <= 3) begin
                sel = int'($urandom_range(0, 4));
                case (sel)
                    0:       prog[p] = enc_r(7'h00, rs2, rs1, 3'b000, rd);
                    1:       prog[p] = enc_r(7'h20, rs2, rs1, 3'b000, rd);
                    2:       prog[p] = enc_r(7'h00, rs2, rs1, 3'b111, rd);
                    3:       prog[p] = enc_r(7'h00, rs2, rs1, 3'b110, rd);
                    default: prog[p] = enc_r(7'h00, rs2, rs1, 3'b010, rd);
                endcase
            end else if (kind <= 5 || kind == 9) begin
                prog[p] = enc_i(int'($urandom_range(0, 4095)), rs1, rd);
            end else if (kind == 6) begin
                prog[p] = enc_lw(4 * int'($urandom_range(0, 31)), $urandom_range(0, 1) ? 30 : 0, rd);
            end else if (kind == 7) begin
                prog[p] = enc_sw(4 * int'($urandom_range(0, 31)), rs2, $urandom_range(0, 1) ? 30 : 0);
                rd = 0;
            end else begin
                prog[p] = enc_beq(4 * int'($urandom_range(2, 5)), rs1,
                                  $urandom_range(0, 1) ? rs1 : rs2);
                rd = 0;
            end
            p++;
            l2 = l1; l1 = rd;
        end
        prog[p++] = NOP;
        prog[p++] = NOP;
        for (int i = 1; i < 30; i++) prog[p++] = enc_sw(4 * i, i, 0);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_up();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        clear_prog();

        // R3 R4 R6: every ALU operation, immediate extremes, back-to-back stores
        prog[0]  = enc_i(7, 0, 1);
        prog[1]  = enc_i(-3, 0, 2);
        prog[2]  = enc_i(2047, 0, 9);
        prog[3]  = enc_i(-2048, 0, 10);
        prog[4]  = enc_r(7'h00, 2, 1, 3'b000, 3);
        prog[5]  = enc_r(7'h20, 2, 1, 3'b000, 4);
        prog[6]  = enc_r(7'h00, 2, 1, 3'b111, 5);
        prog[7]  = enc_r(7'h00, 2, 1, 3'b110, 6);
        prog[8]  = enc_r(7'h00, 1, 2, 3'b010, 7);
        prog[9]  = enc_r(7'h00, 2, 1, 3'b010, 8);
        prog[10] = NOP;
        prog[11] = NOP;
        for (int i = 3; i <= 10; i++) prog[9 + i] = enc_sw(4 * i, i, 0);
        run_prog("R3/R4/R6 alu ops and retire rate", 1'b1);

        // R8: x0 ignores writes and reads as zero
        clear_prog();
        prog[0]  = enc_i(9, 0, 1);
        prog[3]  = enc_i(5, 0, 0);
        prog[4]  = enc_r(7'h00, 1, 1, 3'b000, 0);
        prog[7]  = enc_sw(0, 0, 0);
        prog[8]  = enc_r(7'h00, 1, 0, 3'b000, 3);
        prog[11] = enc_sw(4, 3, 0);
        run_prog("R8 zero register", 1'b0);

        // R7: taken branch squashes three, not-taken falls through
        clear_prog();
        prog[0]  = enc_i(1, 0, 1);
        prog[3]  = enc_beq(16, 1, 1);
        prog[4]  = enc_sw(4, 1, 0);
        prog[5]  = enc_sw(8, 1, 0);
        prog[6]  = enc_sw(12, 1, 0);
        prog[7]  = enc_sw(16, 1, 0);
        prog[8]  = enc_beq(8, 0, 1);
        prog[9]  = enc_sw(20, 1, 0);
        prog[10] = enc_beq(12, 0, 0);
        prog[11] = enc_sw(24, 1, 0);
        prog[14] = enc_sw(28, 1, 0);
        run_prog("R7 branch redirect and squash", 1'b0);

        // R5 R9: load/store at distance three, store then load same word
        clear_prog();
        prog[0]  = enc_lw(8, 0, 2);
        prog[3]  = enc_sw(12, 2, 0);
        prog[4]  = enc_i(1, 2, 3);
        prog[5]  = enc_i(40, 0, 6);
        prog[7]  = enc_sw(16, 3, 0);
        prog[8]  = enc_sw(4, 3, 6);
        prog[9]  = enc_lw(4, 6, 4);
        prog[12] = enc_sw(48, 4, 0);
        run_prog("R5/R9 memory path and write-back bypass", 1'b0);

        // R10: unsupported encodings are no-ops
        clear_prog();
        prog[0]  = enc_i(33, 0, 5);
        prog[3]  = enc_r(7'h00, 5, 5, 3'b100, 5);
        prog[4]  = {12'd0, 5'd0, 3'b000, 5'd5, 7'h03};
        prog[5]  = 32'hFFFF_FFFF;
        prog[6]  = 32'h0000_0073;
        prog[7]  = {12'd1, 5'd5, 3'b001, 5'd5, 7'h13};
        prog[8]  = {7'h00, 5'd5, 5'd0, 3'b000, 5'd8, 7'h23};
        prog[9]  = enc_r(7'h01, 5, 5, 3'b000, 5);
        prog[12] = enc_sw(0, 5, 0);
        run_prog("R10 unsupported encodings", 1'b0);

        // random programs: R3 R4 R5 R6 R7 R9 together
        for (int n = 0; n < 6; n++) begin
            gen_random();
            run_prog("R6 random program", 1'b0);
        end

        finish_up();
    end

endmodule